// File: doc/BRIEF.md
# In-Order Retirement Buffer with Deferred Faults

This block tracks instructions between dispatch and retirement in a machine that executes out of order. Up to two instructions are allocated per cycle, in program order, into a circular buffer of entries. Each allocation returns a tag. Execution units later report completion against that tag, in any order, with a result value and a fault flag. The buffer retires instructions strictly in program order from the oldest entry. It retires up to two per cycle and presents each one on a commit port. The commit port carries the destination register write for the architectural file, or a release strobe for a buffered store.

A fault reported by an execution unit is only noted inside the entry. It becomes a visible exception only when that entry is the oldest one left. At that point nothing at or after it retires, and the buffer empties itself so the front end can redirect. A branch mispredict input names the branch's tag. Every entry younger than the branch is discarded in that cycle, and allocation resumes in the slot right after the branch. Faults held by discarded entries disappear without a trace.

Top module: `rob_core`

## Requirements
- R1: Allocation requests are given by `disp_vld` as 2'b00, 2'b01 or 2'b11. `disp_ready` is high only when no flush or exception is present and the number of free entries is at least the number requested. Accepted instructions get consecutive tags, modulo 32, from the tail, slot 0 first; nothing is allocated when `disp_ready` is low.
- R2: An entry retires only when it is the oldest, has completed, and all older entries have retired. Up to two retire per cycle, in order. Lane 0 is the oldest, and lane 1 is used only together with lane 0. Each lane carries the entry's destination and result.
- R3: Retirement stops at the first entry that has not completed or that holds a fault, even if younger entries are complete.
- R4: A store entry raises `cm_st` on its lane only in the cycle it retires.
- R5: A fault raises no output while the entry is younger than the oldest. When the faulting entry is the oldest, `exc_vld` is high with `exc_tag` equal to its tag and no lane retires. On the next cycle the buffer is empty, and the next allocation reuses that tag.
- R6: A fault held by an entry discarded by a mispredict flush is never reported.
- R7: A flush with `flush_tag` discards every entry younger than that tag in the same cycle. The next allocated tag is `flush_tag`+1. `disp_ready` is low during the flush cycle.
- R8: A completion whose tag names an entry that is not live is ignored. A later instruction allocated into that slot stays incomplete until it gets its own completion.
- R9: After reset the buffer is empty: `disp_ready` high, no retirement, no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_vld | input | 2 | Allocation request per slot (slot 1 only with slot 0) |
| disp_dst | input | 10 | Destination register per slot, slot 0 in low bits |
| disp_wen | input | 2 | Slot writes a register |
| disp_st | input | 2 | Slot is a store |
| disp_ready | output | 1 | Request can be accepted this cycle |
| disp_tag0 | output | 5 | Tag given to slot 0 |
| disp_tag1 | output | 5 | Tag given to slot 1 |
| wb_vld | input | 1 | Completion report valid |
| wb_tag | input | 5 | Tag of the completing entry |
| wb_data | input | 32 | Result value |
| wb_exc | input | 1 | Entry faulted |
| flush_vld | input | 1 | Mispredict flush |
| flush_tag | input | 5 | Tag of the mispredicted branch |
| cm_vld | output | 2 | Lane retires this cycle |
| cm_wen | output | 2 | Retiring lane writes a register |
| cm_st | output | 2 | Retiring lane releases a store |
| cm_dst | output | 10 | Destination per lane |
| cm_data | output | 64 | Result per lane |
| exc_vld | output | 1 | Precise exception at the oldest entry |
| exc_tag | output | 5 | Tag of the faulting entry |

## Verification
The assertions take for granted that `disp_vld` never shows 2'b10. They also assume that a flush names a live entry, and that no completion names a slot that was squashed and then allocated again before the stale report arrives. The stimulus keeps to this. It only requests slot 1 together with slot 0, and it flushes a branch whose tag the bench got back from allocation. It sends its stale completion after the flush and before the slot is reused. The scoreboard follows tags in program order and truncates its queue on each flush.

// File: rtl/rob_core.sv
module rob_core #(
  parameter int DEPTH = 32,
  parameter int XLEN  = 32,
  parameter int AREGW = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 disp_vld,
  input  logic [2*AREGW-1:0]         disp_dst,
  input  logic [1:0]                 disp_wen,
  input  logic [1:0]                 disp_st,
  output logic                       disp_ready,
  output logic [$clog2(DEPTH)-1:0]   disp_tag0,
  output logic [$clog2(DEPTH)-1:0]   disp_tag1,
  input  logic                       wb_vld,
  input  logic [$clog2(DEPTH)-1:0]   wb_tag,
  input  logic [XLEN-1:0]            wb_data,
  input  logic                       wb_exc,
  input  logic                       flush_vld,
  input  logic [$clog2(DEPTH)-1:0]   flush_tag,
  output logic [1:0]                 cm_vld,
  output logic [1:0]                 cm_wen,
  output logic [1:0]                 cm_st,
  output logic [2*AREGW-1:0]         cm_dst,
  output logic [2*XLEN-1:0]          cm_data,
  output logic                       exc_vld,
  output logic [$clog2(DEPTH)-1:0]   exc_tag
);
  localparam int TW = $clog2(DEPTH);
  localparam int PW = TW + 1;

  logic [PW-1:0] head, tail, count, free;
  logic [TW-1:0] h0, h1, t0, t1, off_f;
  logic [DEPTH-1:0] vld, done, fault, wen, st;
  logic [AREGW-1:0] dst [DEPTH];
  logic [XLEN-1:0] data [DEPTH];
  logic [1:0] nreq, ncm;
  logic c0, c1, disp_fire;

  assign count = tail - head;
  assign free  = PW'(DEPTH) - count;
  assign h0 = head[TW-1:0];
  assign h1 = h0 + TW'(1);
  assign t0 = tail[TW-1:0];
  assign t1 = t0 + TW'(1);
  assign off_f = flush_tag - h0;
  assign nreq = {1'b0, disp_vld[0]} + {1'b0, disp_vld[1]};

  assign exc_vld = vld[h0] & done[h0] & fault[h0];
  assign exc_tag = h0;

  assign disp_ready = !flush_vld && !exc_vld && (free >= PW'(nreq));
  assign disp_fire  = disp_ready && disp_vld[0];
  assign disp_tag0  = t0;
  assign disp_tag1  = t1;

  assign c0 = vld[h0] & done[h0] & ~fault[h0];
  assign c1 = c0 & vld[h1] & done[h1] & ~fault[h1] & (!flush_vld || off_f != '0);
  assign ncm = {1'b0, c0} + {1'b0, c1};

  assign cm_vld  = {c1, c0};
  assign cm_wen  = {c1 & wen[h1], c0 & wen[h0]};
  assign cm_st   = {c1 & st[h1], c0 & st[h0]};
  assign cm_dst  = {dst[h1], dst[h0]};
  assign cm_data = {data[h1], data[h0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      vld   <= '0;
      done  <= '0;
      fault <= '0;
      wen   <= '0;
      st    <= '0;
    end else begin
      if (wb_vld && vld[wb_tag]) begin
        done[wb_tag]  <= 1'b1;
        fault[wb_tag] <= wb_exc;
        data[wb_tag]  <= wb_data;
      end
      if (c0) vld[h0] <= 1'b0;
      if (c1) vld[h1] <= 1'b0;
      head <= head + PW'(ncm);
      if (exc_vld) begin
        vld  <= '0;
        tail <= head;
      end else if (flush_vld) begin
        tail <= head + PW'(off_f) + PW'(1);
        for (int i = 0; i < DEPTH; i++)
          if (TW'(i) - h0 > off_f) vld[i] <= 1'b0;
      end else if (disp_fire) begin
        vld[t0]   <= 1'b1;
        done[t0]  <= 1'b0;
        fault[t0] <= 1'b0;
        wen[t0]   <= disp_wen[0];
        st[t0]    <= disp_st[0];
        dst[t0]   <= disp_dst[AREGW-1:0];
        if (disp_vld[1]) begin
          vld[t1]   <= 1'b1;
          done[t1]  <= 1'b0;
          fault[t1] <= 1'b0;
          wen[t1]   <= disp_wen[1];
          st[t1]    <= disp_st[1];
          dst[t1]   <= disp_dst[2*AREGW-1:AREGW];
        end
        tail <= tail + PW'(nreq);
      end
    end
  end

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= PW'(DEPTH));
  // R2
  head_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) |-> vld[h0]);
  // R9
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (cm_vld == 2'b00 && !exc_vld));
  // R5
  exc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld |-> (cm_vld == 2'b00));
  // R5
  exc_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_vld |=> (count == '0));
  // R7
  flush_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_vld && !exc_vld) |=> (count <= $past(count)));
endmodule

// File: tb/rob_core_tb.sv
module rob_core_tb;
  localparam int DEPTH = 32;
  localparam int XLEN  = 32;
  localparam int AW    = 5;
  localparam int TW    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] disp_vld = '0;
  logic [2*AW-1:0] disp_dst = '0;
  logic [1:0] disp_wen = '0, disp_st = '0;
  logic disp_ready;
  logic [TW-1:0] disp_tag0, disp_tag1;
  logic wb_vld = 1'b0;
  logic [TW-1:0] wb_tag = '0;
  logic [XLEN-1:0] wb_data = '0;
  logic wb_exc = 1'b0;
  logic flush_vld = 1'b0;
  logic [TW-1:0] flush_tag = '0;
  logic [1:0] cm_vld, cm_wen, cm_st;
  logic [2*AW-1:0] cm_dst;
  logic [2*XLEN-1:0] cm_data;
  logic exc_vld;
  logic [TW-1:0] exc_tag;

  rob_core u_dut (
    .clk(clk), .rst_n(rst_n),
    .disp_vld(disp_vld), .disp_dst(disp_dst), .disp_wen(disp_wen), .disp_st(disp_st),
    .disp_ready(disp_ready), .disp_tag0(disp_tag0), .disp_tag1(disp_tag1),
    .wb_vld(wb_vld), .wb_tag(wb_tag), .wb_data(wb_data), .wb_exc(wb_exc),
    .flush_vld(flush_vld), .flush_tag(flush_tag),
    .cm_vld(cm_vld), .cm_wen(cm_wen), .cm_st(cm_st), .cm_dst(cm_dst), .cm_data(cm_data),
    .exc_vld(exc_vld), .exc_tag(exc_tag)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, nt = 0;
  bit finished = 1'b0;
  int q[$];
  logic [XLEN-1:0] m_data [DEPTH];
  logic [AW-1:0] m_dst [DEPTH];
  bit m_st [DEPTH];
  bit m_exc [DEPTH];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit live(input int t);
    foreach (q[i]) if (q[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (exc_vld) begin
      if (q.size() == 0) chk("R5", "exception with empty model", 1, 0);
      else begin
        chk("R5", "exception tag", exc_tag, q[0]);
        chk("R6", "exception on live fault", m_exc[q[0]], 1);
        nt = q[0];
        q.delete();
      end
    end
    for (int k = 0; k < 2; k++) if (cm_vld[k]) begin
      if (q.size() == 0) chk("R2", "retire with empty model", 1, 0);
      else begin
        int t;
        t = q.pop_front();
        chk("R2", "retire dst", cm_dst[k*AW +: AW], m_dst[t]);
        chk("R2", "retire data", cm_data[k*XLEN +: XLEN], m_data[t]);
        chk("R4", "store release", cm_st[k], m_st[t]);
        chk("R2", "register write", cm_wen[k], !m_st[t]);
      end
    end
  end

  task automatic disp(input int n, input logic [AW-1:0] d0, input logic [AW-1:0] d1,
                      input bit s0, input bit s1, input bit exp_rdy);
    disp_vld = (n == 2) ? 2'b11 : (n == 1) ? 2'b01 : 2'b00;
    disp_dst = {d1, d0};
    disp_st  = {s1, s0};
    disp_wen = {~s1, ~s0};
    @(negedge clk);
    chk("R1", "dispatch ready", disp_ready, exp_rdy);
    if (disp_ready) begin
      chk("R1", "tag slot 0", disp_tag0, nt);
      q.push_back(nt); m_dst[nt] = d0; m_st[nt] = s0; m_exc[nt] = 0;
      nt = (nt + 1) % DEPTH;
      if (n == 2) begin
        chk("R1", "tag slot 1", disp_tag1, nt);
        q.push_back(nt); m_dst[nt] = d1; m_st[nt] = s1; m_exc[nt] = 0;
        nt = (nt + 1) % DEPTH;
      end
    end
    @(posedge clk); #1;
    disp_vld = 2'b00;
  endtask

  task automatic wb(input int t, input logic [XLEN-1:0] d, input bit e);
    wb_vld = 1'b1; wb_tag = TW'(t); wb_data = d; wb_exc = e;
    @(negedge clk);
    if (live(t)) begin m_data[t] = d; m_exc[t] = e; end
    @(posedge clk); #1;
    wb_vld = 1'b0; wb_exc = 1'b0;
  endtask

  task automatic flush(input int t);
    flush_vld = 1'b1; flush_tag = TW'(t);
    disp_vld = 2'b01;
    @(negedge clk);
    chk("R7", "ready low during flush", disp_ready, 0);
    chk("R6", "no exception on flush", exc_vld, 0);
    foreach (q[i]) if (q[i] == t) begin
      while (q.size() > i + 1) void'(q.pop_back());
      break;
    end
    nt = (t + 1) % DEPTH;
    @(posedge clk); #1;
    flush_vld = 1'b0; disp_vld = 2'b00;
  endtask

  task automatic step_chk(input logic [1:0] exp_cm, input bit exp_exc, input string req);
    @(negedge clk);
    chk(req, "retire lanes", cm_vld, exp_cm);
    chk(req, "exception flag", exc_vld, exp_exc);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9", "ready after reset", disp_ready, 1);
    chk("R9", "no retire after reset", cm_vld, 0);
    chk("R9", "no exception after reset", exc_vld, 0);
    @(posedge clk); #1;

    // R2 R3 out-of-order completion, in-order retirement
    disp(2, 5'd1, 5'd2, 0, 0, 1);
    disp(1, 5'd3, 5'd0, 0, 0, 1);
    wb(2, 32'hC2, 0);
    wb(1, 32'hB1, 0);
    step_chk(2'b00, 0, "R3");
    wb(0, 32'hA0, 0);
    step_chk(2'b11, 0, "R2");
    step_chk(2'b01, 0, "R2");
    step_chk(2'b00, 0, "R2");

    // R4 store released only at retirement
    disp(2, 5'd4, 5'd5, 1, 0, 1);
    step_chk(2'b00, 0, "R4");
    wb(3, 32'h33, 0);
    @(negedge clk);
    chk("R4", "store strobe at retire", cm_st, 2'b01);
    @(posedge clk); #1;
    wb(4, 32'h44, 0);
    step_chk(2'b01, 0, "R2");

    // R5 deferred fault, precise at the oldest entry
    disp(2, 5'd6, 5'd7, 0, 0, 1);
    wb(6, 32'h66, 1);
    step_chk(2'b00, 0, "R5");
    wb(5, 32'h55, 0);
    step_chk(2'b01, 0, "R3");
    @(negedge clk);
    chk("R5", "exception raised", exc_vld, 1);
    chk("R5", "exception tag value", exc_tag, 6);
    chk("R5", "nothing retires with exception", cm_vld, 0);
    @(posedge clk); #1;

    // R6 R7 R8 squash with a wrong-path fault and a stale completion
    disp(2, 5'd8, 5'd9, 0, 0, 1);
    chk("R5", "tag reused after exception", q[0], 6);
    disp(1, 5'd10, 5'd0, 0, 0, 1);
    wb(8, 32'h88, 1);
    flush(6);
    wb(7, 32'h77, 0);
    wb(6, 32'h6B, 0);
    step_chk(2'b01, 0, "R6");
    step_chk(2'b00, 0, "R6");
    step_chk(2'b00, 0, "R6");
    step_chk(2'b00, 0, "R6");
    disp(1, 5'd11, 5'd0, 0, 0, 1);
    chk("R7", "next tag after flush", q[0], 7);
    step_chk(2'b00, 0, "R8");
    step_chk(2'b00, 0, "R8");
    wb(7, 32'h7700, 0);
    step_chk(2'b01, 0, "R8");

    // R1 fill to capacity, then R3 R2 drain with wraparound
    for (int i = 0; i < 15; i++) disp(2, AW'(i), AW'(i + 1), 0, 0, 1);
    disp(1, 5'd20, 5'd0, 0, 0, 1);
    disp(2, 5'd21, 5'd22, 0, 0, 0);
    disp(1, 5'd23, 5'd0, 0, 0, 1);
    disp(1, 5'd24, 5'd0, 0, 0, 0);
    chk("R1", "model holds full buffer", q.size(), 32);
    for (int k = 31; k >= 1; k--) wb((8 + k) % DEPTH, 32'hD000_0000 + k, 0);
    step_chk(2'b00, 0, "R3");
    wb(8, 32'hD000_0000, 0);
    for (int k = 0; k < 16; k++) step_chk(2'b11, 0, "R2");
    step_chk(2'b00, 0, "R2");
    chk("R2", "all entries retired", q.size(), 0);
    disp(2, 5'd1, 5'd2, 0, 0, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule